// File: doc/BRIEF.md
# Clock-Enable Reset Sequencer

This block sits on the controller side of a DDR-style memory interface. It takes the memory device through a reset that is carried out with the clock-enable pin alone. A reset request drops CKE at once, even in the middle of a read or write burst. The memory clock keeps running for a programmable delay and is then gated off for a programmable hold. After that the clock is restored and left to settle before CKE is raised again. The block then hands control to an external initialization engine and reports readiness only after that engine finishes.

The sequence runs through seven states, and each timed state uses one shared down-counter.

- IDLE is entered from system reset and waits for a request.
- IDLE to CKE_LOW_WAIT happens on a request.
- CKE_LOW_WAIT to CLK_OFF happens once the low delay has run out.
- CLK_OFF to CLK_STABLE_WAIT happens once the clock-off hold has run out.
- CLK_STABLE_WAIT to CKE_HIGH happens once the stability wait has run out.
- CKE_HIGH to INIT_WAIT happens once the minimum high hold has run out.
- INIT_WAIT to READY happens when init done is sampled.

A request in any state, READY included, sends the machine back to CKE_LOW_WAIT.

While the sequence is in progress, the command-select output keeps the command bus limited to NOP or DESELECT. The parameters are:

- `LOW_DLY_CYC`: how long the clock keeps running after CKE falls.
- `CLK_OFF_CYC`: how long the clock stays gated off.
- `STABLE_CYC`: how long the restored clock runs before CKE rises.
- `CKE_MIN_CYC`: the minimum time CKE spends at each level.

Top module: `cke_reset_seq`

## Requirements
- R1: After system reset (rst_n low) the block is in IDLE with cke=0, mem_clk_en=1, cmd_force_nop=1, init_start=0 and ready=0, and it stays there until a request arrives.
- R2: While rst_req is high, cke=0, ready=0 and cmd_force_nop=1 in that same cycle, from any state, including READY during traffic.
- R3: After the last cycle in which rst_req is sampled high, the block spends LOW_WAIT = max(LOW_DLY_CYC, CKE_MIN_CYC) cycles in CKE_LOW_WAIT, with cke=0 and mem_clk_en=1. It then spends CLK_OFF_CYC cycles in CLK_OFF, with cke=0 and mem_clk_en=0.
- R4: The clock is then restored and cke stays 0 for STABLE_CYC cycles (CLK_STABLE_WAIT). mem_clk_en is 1 in every cycle in which cke is 1.
- R5: cke then stays 1 for CKE_MIN_CYC cycles (CKE_HIGH) before init_start is raised. Each low interval of cke lasts at least CKE_MIN_CYC cycles.
- R6: init_start is a single-cycle pulse in the first cycle of INIT_WAIT. The block then waits in INIT_WAIT for as long as init_done stays 0. An init_done pulse seen in any other state has no effect.
- R7: ready rises the cycle after init_done is sampled high in INIT_WAIT, and ready is 1 only in READY.
- R8: A request in any state restarts the sequence at CKE_LOW_WAIT with the full timing. A request held high keeps the block in CKE_LOW_WAIT.
- R9: cmd_force_nop is 1 (command bus limited to NOP or DESELECT) in every state except READY, where it is 0 (normal traffic).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| rst_req | input | 1 | Memory reset request, synchronous to clk |
| init_done | input | 1 | Initialization engine reports completion |
| cke | output | 1 | Clock-enable pin drive to the memory |
| mem_clk_en | output | 1 | Gate enable for the memory clock (1 = running) |
| cmd_force_nop | output | 1 | 1 = command bus limited to NOP/DESELECT, 0 = normal traffic |
| init_start | output | 1 | One-cycle start pulse to the initialization engine |
| ready | output | 1 | Device reinitialized and open for traffic |

## Verification
The assertions assume that rst_req and init_done are synchronous to clk and stable around each rising edge. Under that assumption, a fall of cke can only come from a request, and a rise of ready can only follow a sampled init_done. The bench changes every input on the falling edge and holds it through the next rising edge, so the assumption holds. It uses only single-cycle or held-level pulses, with no mid-cycle toggling of the request.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CKE_LOW_WAIT,
        ST_CLK_OFF,
        ST_CLK_STABLE_WAIT,
        ST_CKE_HIGH,
        ST_INIT_WAIT,
        ST_READY
    } crs_state_e;

endpackage

// File: rtl/crs_timer.sv
// Shared down-counter: loaded on state entry, saturates at zero.
module crs_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/crs_fsm.sv
// State register and next-state logic.
module crs_fsm
    import crs_pkg::*;
#(
    parameter int W          = 4,
    parameter int LOW_WAIT   = 4,
    parameter int OFF_CYC    = 3,
    parameter int STABLE_CYC = 6,
    parameter int CKE_MIN    = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rst_req,
    input  logic         init_done,
    input  logic         expired,
    output crs_state_e   state,
    output logic         load,
    output logic [W-1:0] load_val
);

    localparam logic [W-1:0] LD_LOW    = W'(LOW_WAIT - 1);
    localparam logic [W-1:0] LD_OFF    = W'(OFF_CYC - 1);
    localparam logic [W-1:0] LD_STABLE = W'(STABLE_CYC - 1);
    localparam logic [W-1:0] LD_HIGH   = W'(CKE_MIN - 1);
    localparam logic [W-1:0] LD_PULSE  = W'(1);

    crs_state_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        load_val  = '0;
        if (rst_req) begin
            state_nxt = ST_CKE_LOW_WAIT;
            load      = 1'b1;
            load_val  = LD_LOW;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_nxt = ST_IDLE;
                end
                ST_CKE_LOW_WAIT: begin
                    if (expired) begin
                        state_nxt = ST_CLK_OFF;
                        load      = 1'b1;
                        load_val  = LD_OFF;
                    end
                end
                ST_CLK_OFF: begin
                    if (expired) begin
                        state_nxt = ST_CLK_STABLE_WAIT;
                        load      = 1'b1;
                        load_val  = LD_STABLE;
                    end
                end
                ST_CLK_STABLE_WAIT: begin
                    if (expired) begin
                        state_nxt = ST_CKE_HIGH;
                        load      = 1'b1;
                        load_val  = LD_HIGH;
                    end
                end
                ST_CKE_HIGH: begin
                    if (expired) begin
                        state_nxt = ST_INIT_WAIT;
                        load      = 1'b1;
                        load_val  = LD_PULSE;
                    end
                end
                ST_INIT_WAIT: begin
                    if (init_done) begin
                        state_nxt = ST_READY;
                    end
                end
                ST_READY: begin
                    state_nxt = ST_READY;
                end
                default: begin
                    state_nxt = ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/crs_outdec.sv
// Output decode from state; a live request overrides CKE, ready and command select.
module crs_outdec
    import crs_pkg::*;
(
    input  crs_state_e state,
    input  logic       rst_req,
    input  logic       expired,
    output logic       cke,
    output logic       mem_clk_en,
    output logic       cmd_force_nop,
    output logic       init_start,
    output logic       ready
);

    logic cke_st;
    logic nop_st;
    logic rdy_st;

    always_comb begin
        cke_st     = 1'b0;
        mem_clk_en = 1'b1;
        nop_st     = 1'b1;
        init_start = 1'b0;
        rdy_st     = 1'b0;
        unique case (state)
            ST_IDLE:            ;
            ST_CKE_LOW_WAIT:    ;
            ST_CLK_OFF:         mem_clk_en = 1'b0;
            ST_CLK_STABLE_WAIT: ;
            ST_CKE_HIGH:        cke_st = 1'b1;
            ST_INIT_WAIT: begin
                cke_st     = 1'b1;
                init_start = !expired;
            end
            ST_READY: begin
                cke_st = 1'b1;
                nop_st = 1'b0;
                rdy_st = 1'b1;
            end
            default:            ;
        endcase
    end

    assign cke           = cke_st & ~rst_req;
    assign ready         = rdy_st & ~rst_req;
    assign cmd_force_nop = nop_st | rst_req;

endmodule

// File: rtl/cke_reset_seq.sv
module cke_reset_seq
    import crs_pkg::*;
#(
    parameter int LOW_DLY_CYC = 4,
    parameter int CLK_OFF_CYC = 3,
    parameter int STABLE_CYC  = 6,
    parameter int CKE_MIN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req,
    input  logic init_done,
    output logic cke,
    output logic mem_clk_en,
    output logic cmd_force_nop,
    output logic init_start,
    output logic ready
);

    localparam int LOW_WAIT = (LOW_DLY_CYC > CKE_MIN_CYC) ? LOW_DLY_CYC : CKE_MIN_CYC;
    localparam int MAX_A    = (LOW_WAIT > CLK_OFF_CYC) ? LOW_WAIT : CLK_OFF_CYC;
    localparam int MAX_B    = (STABLE_CYC > CKE_MIN_CYC) ? STABLE_CYC : CKE_MIN_CYC;
    localparam int MAX_CNT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W    = $clog2(MAX_CNT + 2);

    crs_state_e       state;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;

    crs_fsm #(
        .W          (CNT_W),
        .LOW_WAIT   (LOW_WAIT),
        .OFF_CYC    (CLK_OFF_CYC),
        .STABLE_CYC (STABLE_CYC),
        .CKE_MIN    (CKE_MIN_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_req   (rst_req),
        .init_done (init_done),
        .expired   (expired),
        .state     (state),
        .load      (load),
        .load_val  (load_val)
    );

    crs_timer #(
        .W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    crs_outdec u_out (
        .state         (state),
        .rst_req       (rst_req),
        .expired       (expired),
        .cke           (cke),
        .mem_clk_en    (mem_clk_en),
        .cmd_force_nop (cmd_force_nop),
        .init_start    (init_start),
        .ready         (ready)
    );

endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
    parameter int CKE_MIN = 3
) (
    input logic clk,
    input logic rst_n,
    input logic rst_req,
    input logic init_done,
    input logic cke,
    input logic mem_clk_en,
    input logic cmd_force_nop,
    input logic init_start,
    input logic ready
);

    localparam int RUN_W = $clog2(CKE_MIN + 2);

    logic [RUN_W-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (cke) begin
            low_run <= '0;
        end else if (low_run < RUN_W'(CKE_MIN)) begin
            low_run <= low_run + 1'b1;
        end
    end

    a_r2_req_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (!cke && !ready && cmd_force_nop));

    a_r3_clk_off_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_clk_en |-> !cke);

    a_r4_cke_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
        cke |-> mem_clk_en);

    a_r5_cke_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (low_run >= RUN_W'(CKE_MIN)));

    a_r5_start_under_cke: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |-> (cke && !ready));

    a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |=> !init_start);

    a_r7_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(init_done));

    a_r8_fall_only_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> rst_req);

    a_r9_nop_unless_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> cmd_force_nop);

endmodule

bind cke_reset_seq crs_checker #(.CKE_MIN(CKE_MIN_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rst_req       (rst_req),
    .init_done     (init_done),
    .cke           (cke),
    .mem_clk_en    (mem_clk_en),
    .cmd_force_nop (cmd_force_nop),
    .init_start    (init_start),
    .ready         (ready)
);

// File: tb/tb_cke_reset_seq.sv
module tb_cke_reset_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_req = 1'b0;
    logic init_done = 1'b0;
    logic cke, mem_clk_en, cmd_force_nop, init_start, ready;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cke_reset_seq dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rst_req       (rst_req),
        .init_done     (init_done),
        .cke           (cke),
        .mem_clk_en    (mem_clk_en),
        .cmd_force_nop (cmd_force_nop),
        .init_start    (init_start),
        .ready         (ready)
    );

    // Per cycle after the request is released: {init_done to drive, cke, clk_en, nop, start, ready}
    // Defaults: LOW_WAIT 4, CLK_OFF 3, STABLE 6, CKE_MIN 3.
    localparam logic [5:0] SEQ [0:18] = '{
        6'b001100, 6'b001100, 6'b001100, 6'b001100,
        6'b000100, 6'b000100, 6'b000100,
        6'b001100, 6'b001100, 6'b001100, 6'b001100, 6'b001100, 6'b001100,
        6'b011100, 6'b011100, 6'b011100,
        6'b011110,
        6'b111100,
        6'b011001
    };

    localparam logic [4:0] IDLE_OUT  = 5'b01100;
    localparam logic [4:0] INIT_HOLD = 5'b11100;
    localparam logic [4:0] READY_OUT = 5'b11001;

    function automatic string tag_of(input int k);
        if (k < 7)       return "R3";
        else if (k < 13) return "R4";
        else if (k < 16) return "R5";
        else if (k < 18) return "R6";
        else             return "R7";
    endfunction

    task automatic chk(input string tag, input logic [4:0] exp);
        logic [4:0] got;
        got = {cke, mem_clk_en, cmd_force_nop, init_start, ready};
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {cke,clk_en,nop,start,ready} actual %b expected %b", tag, got, exp);
        end
    endtask

    // Request: raise, hold for `hold` sampled edges, release at the following negedge.
    task automatic request(input int hold);
        @(negedge clk);
        rst_req = 1'b1;
        #1;
        chk("R2", {1'b0, mem_clk_en, 1'b1, 1'b0, 1'b0});
        for (int i = 1; i < hold; i++) begin
            @(negedge clk);
            chk("R8", IDLE_OUT);
        end
        @(negedge clk);
        rst_req = 1'b0;
    endtask

    // Walk the first n table cycles; optional spurious init_done at cycle spur.
    task automatic walk(input int n, input int spur);
        for (int k = 0; k < n; k++) begin
            chk(tag_of(k), SEQ[k][4:0]);
            init_done = SEQ[k][5] | (k == spur);
            @(negedge clk);
        end
        init_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state and idling without a request
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", IDLE_OUT);
        repeat (5) @(negedge clk);
        chk("R1", IDLE_OUT);

        // R8: request from IDLE, then full table walk (R3..R7)
        request(1);
        walk(19, -1);

        // R2, R8: request while READY, held four cycles, full sequence again
        request(4);
        walk(19, -1);
        chk("R9", READY_OUT);

        // R8: restart while the clock is gated off
        request(1);
        walk(6, -1);
        chk("R3", 5'b00100);
        rst_req = 1'b1;
        #1;
        chk("R2", 5'b00100);
        @(negedge clk);
        rst_req = 1'b0;
        walk(19, -1);

        // R6: init_done during CLK_STABLE_WAIT has no effect
        request(1);
        walk(19, 9);

        // R6, R7: init_done withheld keeps the block in INIT_WAIT
        request(1);
        walk(17, -1);
        for (int i = 0; i < 20; i++) begin
            chk("R6", INIT_HOLD);
            @(negedge clk);
        end
        init_done = 1'b1;
        @(negedge clk);
        init_done = 1'b0;
        chk("R7", READY_OUT);

        // R1: system reset in the middle of a sequence
        request(1);
        walk(9, -1);
        rst_n = 1'b0;
        #1;
        chk("R1", IDLE_OUT);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", IDLE_OUT);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule